// File: doc/BRIEF.md
# Lane-Partitioned SIMD Adder

A combinational 48-bit adder whose carry chain can be cut into independent lanes. A two-bit mode input selects the layout: one 48-bit lane, two 24-bit lanes, or four 12-bit lanes. Carries never cross a cut boundary, and each lane reports its own carry-out. Several narrow additions can therefore share one wide adder without affecting each other.

The first addend is assembled from two ports. A 30-bit upper part supplies word bits 47:18 and an 18-bit lower part supplies bits 17:0. The second addend is a separate 48-bit port. A 7-bit source-select code decides what feeds the adder. Only the code that sums the assembled word with the second port is implemented, and every other code leaves the adder idle.

A lane result is the lane's slice of the sum output, with that lane's carry bit placed on top as the most significant bit. A packer that puts narrower operands into a lane extends them to the lane width before packing. An unused lane is fed zeros.

Top module: `simd_lane_adder`

## Requirements
- R1: The first addend X is {a_hi_i, b_lo_i}: a_hi_i drives X[47:18] and b_lo_i drives X[17:0].
- R2: With mode_i = 2'b10 or 2'b11 (four-lane), lane k covers bits 12k+11:12k for k = 0..3. p_o holds that slice of (X + c_i) mod 2^12, and co_o[k] is the carry out of that 12-bit lane.
- R3: In four-lane mode, a carry out of one lane has no effect on the next higher lane.
- R4: With mode_i = 2'b01 (two-lane), p_o[23:0] and p_o[47:24] are independent 24-bit sums. co_o[1] and co_o[3] carry out of bit 23 and bit 47, and co_o[0] = co_o[2] = 0.
- R5: With mode_i = 2'b00 (single lane), p_o is X + c_i mod 2^48. co_o[3] is the carry out of bit 47, and co_o[2:0] = 0.
- R6: The source code 7'b0110011 selects the sum X + c_i. Any other code drives p_o = 0 and co_o = 0 whatever the operands.
- R7: A lane whose X and c_i slices are both zero gives a zero sum and a zero carry. This holds whatever the other lanes carry, including all-ones in the lane below.
- R8: All-ones operands give the largest lane result: 12'hFFF + 12'hFFF produces lane sum 12'hFFE with carry 1 in each lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Lane layout: 00 one lane, 01 two lanes, 10/11 four lanes |
| src_sel_i | input | 7 | Source-select code; 7'b0110011 enables X + c_i |
| a_hi_i | input | 30 | Upper part of the first addend (bits 47:18) |
| b_lo_i | input | 18 | Lower part of the first addend (bits 17:0) |
| c_i | input | 48 | Second addend |
| p_o | output | 48 | Lane sums |
| co_o | output | 4 | Per-lane carry-outs, one slot per 12-bit segment |

## Verification
The hardest case to produce from the ports is a lane that generates a carry exactly at a cut boundary while the lane above sits at all-ones. Any leak of that carry would then ripple through the whole upper lane and wrap it to zero. The stimulus table pairs 12'hFFF with 12'h001 in one lane and fills the neighbour with all-ones or zeros, so a leaked carry changes a whole lane instead of one low bit. The same operands are then repeated under the two-lane and single-lane layouts, which must let the carry through. The cut therefore has to switch with the mode, and cannot simply be a fixed break.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  localparam int SEG_W  = 12;
  localparam int N_SEG  = 4;
  localparam int WORD_W = SEG_W * N_SEG;

  localparam logic [6:0] SRC_XC = 7'b0110011;

  typedef enum logic [1:0] {
    LAYOUT_ONE  = 2'b00,
    LAYOUT_TWO  = 2'b01,
    LAYOUT_FOUR = 2'b10,
    LAYOUT_ALT4 = 2'b11
  } layout_e;

  // Segment i ends a lane when its bit is set.
  function automatic logic [N_SEG-1:0] lane_end_mask(input logic [1:0] mode);
    logic [N_SEG-1:0] m;
    m = '0;
    for (int i = 0; i < N_SEG; i++) begin
      case (mode)
        LAYOUT_ONE: m[i] = (i == N_SEG-1);
        LAYOUT_TWO: m[i] = (i % 2 == 1);
        default:    m[i] = 1'b1;
      endcase
    end
    return m;
  endfunction

  // Segment adder: returns {carry, sum}.
  function automatic logic [SEG_W:0] seg_add(input logic [SEG_W-1:0] x,
                                             input logic [SEG_W-1:0] z,
                                             input logic             cin);
    return {1'b0, x} + {1'b0, z} + {{SEG_W{1'b0}}, cin};
  endfunction

endpackage

// File: rtl/simd_src_sel.sv
module simd_src_sel
  import simd_add_pkg::*;
#(
  parameter int HI_W = 30,
  parameter int LO_W = 18,
  localparam int W = HI_W + LO_W
) (
  input  logic [6:0]   src_sel_i,
  input  logic [HI_W-1:0] a_hi_i,
  input  logic [LO_W-1:0] b_lo_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] x_o,
  output logic [W-1:0] z_o,
  output logic         active_o
);
  always_comb begin
    active_o = (src_sel_i == SRC_XC);
    x_o = active_o ? {a_hi_i, b_lo_i} : '0;
    z_o = active_o ? c_i : '0;
  end
endmodule

// File: rtl/simd_lane_map.sv
module simd_lane_map
  import simd_add_pkg::*;
#(
  parameter int NS = N_SEG
) (
  input  logic [1:0]    mode_i,
  output logic [NS-1:0] lane_end_o,
  output logic [NS-1:0] pass_o
);
  always_comb begin
    lane_end_o = lane_end_mask(mode_i);
    pass_o     = '0;
    for (int i = 1; i < NS; i++) pass_o[i] = ~lane_end_o[i-1];
  end

  always_comb begin
    p_top_ends_r5: assert (lane_end_o[NS-1])
      else $error("top segment must close a lane");
    if (mode_i == LAYOUT_ONE) begin
      p_one_lane_r5: assert ($countones(lane_end_o) == 1)
        else $error("single layout must have one lane");
    end
    if (mode_i == LAYOUT_TWO) begin
      p_two_lane_r4: assert ($countones(lane_end_o) == 2)
        else $error("two-lane layout must have two lanes");
    end
  end
endmodule

// File: rtl/simd_seg_add.sv
module simd_seg_add
  import simd_add_pkg::*;
(
  input  logic [SEG_W-1:0] x_i,
  input  logic [SEG_W-1:0] z_i,
  input  logic             cin_i,
  output logic [SEG_W-1:0] s_o,
  output logic             cout_o
);
  always_comb {cout_o, s_o} = seg_add(x_i, z_i, cin_i);

  always_comb begin
    if (x_i == '0 && z_i == '0 && !cin_i) begin
      p_zero_seg_r7: assert (s_o == '0 && !cout_o)
        else $error("zero segment gave nonzero result");
    end
  end
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_add_pkg::*;
#(
  parameter int HI_W = 30,
  parameter int LO_W = 18,
  localparam int W  = HI_W + LO_W,
  localparam int NS = W / SEG_W
) (
  input  logic [1:0]    mode_i,
  input  logic [6:0]    src_sel_i,
  input  logic [HI_W-1:0] a_hi_i,
  input  logic [LO_W-1:0] b_lo_i,
  input  logic [W-1:0]  c_i,
  output logic [W-1:0]  p_o,
  output logic [NS-1:0] co_o
);
  logic [W-1:0]  x, z;
  logic          active;
  logic [NS-1:0] lane_end, pass;

  simd_src_sel #(.HI_W(HI_W), .LO_W(LO_W)) u_src (
    .src_sel_i(src_sel_i), .a_hi_i(a_hi_i), .b_lo_i(b_lo_i), .c_i(c_i),
    .x_o(x), .z_o(z), .active_o(active)
  );

  simd_lane_map #(.NS(NS)) u_map (
    .mode_i(mode_i), .lane_end_o(lane_end), .pass_o(pass)
  );

  for (genvar i = 0; i < NS; i++) begin : g_seg
    logic             cin;
    logic             cout;
    logic [SEG_W-1:0] s;
    if (i == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_next
      assign cin = g_seg[i-1].cout & pass[i];
    end
    simd_seg_add u_add (
      .x_i(x[i*SEG_W +: SEG_W]), .z_i(z[i*SEG_W +: SEG_W]),
      .cin_i(cin), .s_o(s), .cout_o(cout)
    );
    assign p_o[i*SEG_W +: SEG_W] = s;
    assign co_o[i] = cout & lane_end[i];
  end

  // Lane-level checks relate operands to outputs across separately built pieces.
  always_comb begin
    if (!active) begin
      p_idle_r6: assert (p_o == '0 && co_o == '0)
        else $error("idle source code produced output");
    end
    if (mode_i[1]) begin
      for (int k = 0; k < NS; k++) begin
        p_lane_sum_r2: assert ({co_o[k], p_o[k*SEG_W +: SEG_W]} ==
                               ({1'b0, x[k*SEG_W +: SEG_W]} + {1'b0, z[k*SEG_W +: SEG_W]}))
          else $error("four-lane sum wrong in lane %0d", k);
      end
    end
    if (mode_i == LAYOUT_TWO) begin
      p_two_sum_r4: assert ({co_o[1], p_o[23:0]} == ({1'b0, x[23:0]} + {1'b0, z[23:0]}) &&
                            {co_o[3], p_o[47:24]} == ({1'b0, x[47:24]} + {1'b0, z[47:24]}) &&
                            !co_o[0] && !co_o[2])
        else $error("two-lane sum wrong");
    end
    if (mode_i == LAYOUT_ONE) begin
      p_wide_sum_r5: assert ({co_o[NS-1], p_o} == ({1'b0, x} + {1'b0, z}) &&
                             co_o[NS-2:0] == '0)
        else $error("single-lane sum wrong");
    end
  end
endmodule

// File: tb/simd_lane_adder_test.sv
module simd_lane_adder_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  mode;
  logic [6:0]  sel;
  logic [29:0] a_hi;
  logic [17:0] b_lo;
  logic [47:0] c;
  logic [47:0] p;
  logic [3:0]  co;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  simd_lane_adder uut (
    .mode_i(mode), .src_sel_i(sel), .a_hi_i(a_hi), .b_lo_i(b_lo), .c_i(c),
    .p_o(p), .co_o(co)
  );

  localparam logic [6:0] ADD_XC = 7'b0110011;

  // Entry: {mode, x (48), c (48)}; x is split into a_hi/b_lo by the bench.
  localparam int NV = 12;
  localparam logic [97:0] VEC [NV] = '{
    {2'b10, 48'h000_000_000_FFF, 48'h000_000_000_001},
    {2'b10, 48'hFFF_FFF_FFF_FFF, 48'hFFF_FFF_FFF_FFF},
    {2'b10, 48'h123_456_789_ABC, 48'hEDC_BA9_876_544},
    {2'b11, 48'h800_800_800_800, 48'h800_800_800_800},
    {2'b10, 48'h000_FFF_000_FFF, 48'h000_001_000_001},
    {2'b01, 48'h000_000_FFF_FFF, 48'h000_000_000_001},
    {2'b01, 48'hFFF_FFF_FFF_FFF, 48'h000_001_000_001},
    {2'b01, 48'h5A5_A5A_3C3_C3C, 48'hA5A_5A5_C3C_3C4},
    {2'b00, 48'h000_000_000_FFF, 48'h000_000_000_001},
    {2'b00, 48'hFFF_FFF_FFF_FFF, 48'h000_000_000_001},
    {2'b00, 48'h0F0_F0F_0F0_F0F, 48'h123_456_789_ABC},
    {2'b00, 48'hFFF_FFF_FFF_FFF, 48'hFFF_FFF_FFF_FFF}
  };

  // Reference: lane width from mode, plain wide arithmetic per lane.
  function automatic void ref_add(input logic [1:0] m, input logic [6:0] s,
                                  input logic [47:0] x, input logic [47:0] cc,
                                  output logic [47:0] rp, output logic [3:0] rco);
    int w;
    logic [63:0] mask, lx, lc, sum;
    rp = '0;
    rco = '0;
    if (s != ADD_XC) return;
    w = (m == 2'b00) ? 48 : (m == 2'b01) ? 24 : 12;
    mask = (64'd1 << w) - 64'd1;
    for (int k = 0; k < 48 / w; k++) begin
      lx  = ({16'd0, x} >> (k * w)) & mask;
      lc  = ({16'd0, cc} >> (k * w)) & mask;
      sum = lx + lc;
      rp  = rp | 48'((sum & mask) << (k * w));
      rco[((k + 1) * w) / 12 - 1] = sum[w];
    end
  endfunction

  task automatic apply(input logic [1:0] m, input logic [6:0] s,
                       input logic [47:0] x, input logic [47:0] cc);
    @(negedge clk);
    mode = m; sel = s; a_hi = x[47:18]; b_lo = x[17:0]; c = cc;
    #1;
  endtask

  task automatic check(input string tag, input logic [47:0] ep, input logic [3:0] eco);
    checks++;
    if (p !== ep || co !== eco) begin
      errors++;
      $display("FAIL %s: p=%h co=%b expected p=%h co=%b", tag, p, co, ep, eco);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] m, input logic [6:0] s,
                     input logic [47:0] x, input logic [47:0] cc);
    logic [47:0] ep;
    logic [3:0] eco;
    apply(m, s, x, cc);
    ref_add(m, s, x, cc, ep, eco);
    check(tag, ep, eco);
  endtask

  initial begin
    mode = 2'b10; sel = ADD_XC; a_hi = '0; b_lo = '0; c = '0;
    #1;
    check("R7 initial zero inputs", 48'd0, 4'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] m;
      m = VEC[i][97:96];
      run(m[1] ? "R2/R3 table four-lane" : (m[0] ? "R4 table two-lane" : "R5 table single"),
          m, ADD_XC, VEC[i][95:48], VEC[i][47:0]);
    end

    // R1: port split, lower port alone then upper port alone.
    apply(2'b00, ADD_XC, 48'h000_000_03F_FFF, 48'd0);
    check("R1 lower port lands in bits 17:0", 48'h000_000_03F_FFF, 4'd0);
    @(negedge clk); a_hi = 30'h1; b_lo = '0; c = '0; #1;
    check("R1 upper port lsb lands on bit 18", 48'h000_000_040_000, 4'd0);

    // R3: lane 0 overflows, lane 1 all-ones must stay put.
    apply(2'b10, ADD_XC, 48'h000_000_FFF_FFF, 48'h000_000_000_001);
    check("R3 carry blocked at lane boundary", 48'h000_000_FFF_000, 4'b0001);

    // R4: carry from bit 11 reaches bit 12 but not bit 24.
    apply(2'b01, ADD_XC, 48'h000_FFF_FFF_FFF, 48'h000_000_000_001);
    check("R4 two-lane cut at bit 24", 48'h000_FFF_000_000, 4'b0010);

    // R5: full ripple.
    apply(2'b00, ADD_XC, 48'hFFF_FFF_FFF_FFF, 48'h000_000_000_001);
    check("R5 full-width ripple and top carry", 48'd0, 4'b1000);

    // R6: other codes idle the adder.
    apply(2'b10, 7'b0000000, 48'hFFF_FFF_FFF_FFF, 48'hFFF_FFF_FFF_FFF);
    check("R6 code 0 idle", 48'd0, 4'd0);
    apply(2'b00, 7'b0110010, 48'h123_456_789_ABC, 48'h111_111_111_111);
    check("R6 near-miss code idle", 48'd0, 4'd0);

    // R7: zero lane above an overflowing all-ones lane.
    apply(2'b10, ADD_XC, 48'hFFF_000_FFF_FFF, 48'hFFF_000_001_FFF);
    check("R7 zero lane 2 stays zero", 48'hFFE_000_000_FFE, 4'b1011);

    // R8: all-ones in every lane.
    apply(2'b10, ADD_XC, 48'hFFF_FFF_FFF_FFF, 48'hFFF_FFF_FFF_FFF);
    check("R8 all-ones every lane", 48'hFFE_FFE_FFE_FFE, 4'b1111);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    done = 1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule